// File: doc/BRIEF.md
# Transition-Filtered Event Status Register

This block turns a word of live status flags into a word of latched events. Every clock it samples a 16-bit condition input. It keeps a registered copy of the previous sample and compares the two, bit by bit, to find edges. Each bit has its own edge filter with a 2-bit mode. The mode selects which edges count: rising only, falling only, both, or none. An accepted edge sets the matching bit of the event register, and that bit stays set until software reads the register.

Software picks a filter with a 1-based index and writes its mode. It can read the registered condition word at any time. Reading the event register returns its value and clears it in the same cycle. An edge that lands in that same cycle is kept, because it is applied after the clear.

Condition bits 9, 13 and 15 are not connected to any flag. They always read as zero and can never raise an event.

Top module: `evt_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the event register reads 0, the condition read port reads 0 and every filter is in NEVER mode.
- R2: The condition read port shows the condition input sampled at the previous rising clock edge, with the unused bits forced to 0.
- R3: Condition bits 9, 13 and 15 always read as 0 on both read ports and never set an event bit, whatever mode is written to their filters.
- R4: A write with index n (1 to 16) sets the mode of bit n-1, using the encoding 2'b00 NEVER, 2'b01 RISE, 2'b10 FALL, 2'b11 BOTH. The new mode applies to edges sampled from the next clock edge on.
- R5: In RISE mode, a 0-to-1 change of a condition bit sets its event bit one clock later, and a 1-to-0 change does not.
- R6: In FALL mode, a 1-to-0 change sets the event bit, and a 0-to-1 change does not.
- R7: In BOTH mode, a change in either direction sets the event bit.
- R8: In NEVER mode, the event bit stays 0 whatever the condition bit does.
- R9: A set event bit stays set while no read takes place, even after its condition bit settles.
- R10: When the read strobe is high, the event read port shows the current value, and the register is cleared at the next clock edge.
- R11: An accepted edge sampled in the same cycle as a read is set after the clear, so it is not lost.
- R12: A filter write with an index of 0, or of 17 or more, changes no filter.
- R13: No event is reported in the first active cycle after reset, even if the condition input is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cond_in | input | 16 | Live status flags |
| mode_wr_en | input | 1 | Filter mode write strobe |
| mode_wr_idx | input | 5 | 1-based filter index, 1 to 16 |
| mode_wr_val | input | 2 | Filter mode: 00 NEVER, 01 RISE, 10 FALL, 11 BOTH |
| evt_rd_en | input | 1 | Event read strobe; clears the register at the next edge |
| cond_rd_data | output | 16 | Registered condition word |
| evt_rd_data | output | 16 | Current event register value |

## Verification
Each result is due at a fixed number of rising edges after its stimulus:
- A condition change driven before a rising edge shows on both read ports just after that edge.
- A mode write takes effect for the edge that follows the write edge.
- A read strobe clears the event word at the edge where it is sampled.
- After reset is released, the two-stage synchronizer holds the block in reset for two more edges.

The driver applies stimulus at the falling edge and queues one expected item for the rising edge that follows. The monitor pops and compares each item a quarter period after that rising edge. During the synchronizer lag, the queued items leave the condition value unchecked.

// File: rtl/evtf_pkg.sv
package evtf_pkg;

  typedef enum logic [1:0] {
    FM_NEVER = 2'b00,
    FM_RISE  = 2'b01,
    FM_FALL  = 2'b10,
    FM_BOTH  = 2'b11
  } fmode_e;

  localparam int unsigned FLAG_W = 16;

  localparam logic [FLAG_W-1:0] UNUSED_BITS = 16'hA200;

endpackage

// File: rtl/evtf_rst_sync.sv
module evtf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/evtf_mode_bank.sv
module evtf_mode_bank #(
  parameter int unsigned W   = 16,
  parameter int unsigned IDX = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX-1:0]      wr_idx,
  input  logic [1:0]          wr_val,
  output logic [W-1:0][1:0]   mode
);

  import evtf_pkg::*;

  logic [W-1:0][1:0] mode_q;
  logic [W-1:0][1:0] mode_d;
  logic [W-1:0]      sel;

  for (genvar i = 0; i < W; i++) begin : g_slot
    localparam logic [IDX-1:0] SLOT_IDX = IDX'(i + 1);

    always_comb begin
      sel[i]    = wr_en && (wr_idx == SLOT_IDX);
      mode_d[i] = mode_q[i];
      if (sel[i]) begin
        mode_d[i] = wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[i] <= FM_NEVER;
      end else if (sel[i]) begin
        mode_q[i] <= mode_d[i];
      end
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/evtf_edge_filter.sv
module evtf_edge_filter (
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] mode,
  output logic       hit
);

  import evtf_pkg::*;

  logic rise;
  logic fall;

  always_comb begin
    rise = cur & ~prev;
    fall = ~cur & prev;
    unique case (fmode_e'(mode))
      FM_RISE: hit = rise;
      FM_FALL: hit = fall;
      FM_BOTH: hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int unsigned     W           = evtf_pkg::FLAG_W,
  parameter logic [W-1:0]    UNUSED_MASK = evtf_pkg::UNUSED_BITS,
  localparam int unsigned    IDX         = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cond_in,
  input  logic           mode_wr_en,
  input  logic [IDX-1:0] mode_wr_idx,
  input  logic [1:0]     mode_wr_val,
  input  logic           evt_rd_en,
  output logic [W-1:0]   cond_rd_data,
  output logic [W-1:0]   evt_rd_data
);

  logic              rst_int_n;
  logic [W-1:0][1:0] mode;
  logic [W-1:0]      cond_m;
  logic [W-1:0]      cond_q;
  logic [W-1:0]      cond_d;
  logic [W-1:0]      hit;
  logic [W-1:0]      evt_q;
  logic [W-1:0]      evt_d;
  logic              evt_en;

  evtf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  evtf_mode_bank #(
    .W   (W),
    .IDX (IDX)
  ) u_mode_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (mode_wr_en),
    .wr_idx (mode_wr_idx),
    .wr_val (mode_wr_val),
    .mode   (mode)
  );

  assign cond_m = cond_in & ~UNUSED_MASK;

  for (genvar i = 0; i < W; i++) begin : g_filt
    evtf_edge_filter u_filt (
      .cur  (cond_m[i]),
      .prev (cond_q[i]),
      .mode (mode[i]),
      .hit  (hit[i])
    );
  end

  always_comb begin
    cond_d = cond_m;
    evt_en = evt_rd_en | (|hit);
    evt_d  = evt_q;
    if (evt_rd_en) begin
      evt_d = '0;
    end
    evt_d = evt_d | hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cond_q <= '0;
    end else begin
      cond_q <= cond_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      evt_q <= '0;
    end else if (evt_en) begin
      evt_q <= evt_d;
    end
  end

  assign cond_rd_data = cond_q;
  assign evt_rd_data  = evt_q;

endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int unsigned  W           = 16,
  parameter logic [W-1:0] UNUSED_MASK = 16'hA200
) (
  input logic         clk,
  input logic         rst_n,
  input logic         evt_rd_en,
  input logic [W-1:0] cond_rd_data,
  input logic [W-1:0] evt_rd_data
);

  // R3
  unused_cond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_rd_data & UNUSED_MASK) == '0);

  // R3
  unused_evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_data & UNUSED_MASK) == '0);

  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd_en |=> ((evt_rd_data & $past(evt_rd_data)) == $past(evt_rd_data)));

  // R7
  set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd_en |=> (((evt_rd_data & ~$past(evt_rd_data))
                     & ~(cond_rd_data ^ $past(cond_rd_data))) == '0));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_en |=> ((evt_rd_data & ~(cond_rd_data ^ $past(cond_rd_data))) == '0));

endmodule

bind evt_status_reg evt_status_chk #(
  .W           (W),
  .UNUSED_MASK (UNUSED_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_rd_en    (evt_rd_en),
  .cond_rd_data (cond_rd_data),
  .evt_rd_data  (evt_rd_data)
);

// File: tb/evt_status_reg_tb.sv
module evt_status_reg_tb;

  localparam int CLK_P = 10;

  typedef struct {
    logic [15:0] exp_evt;
    logic        chk_cond;
    logic [15:0] exp_cond;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] cond_in;
  logic        mode_wr_en;
  logic [4:0]  mode_wr_idx;
  logic [1:0]  mode_wr_val;
  logic        evt_rd_en;
  logic [15:0] cond_rd_data;
  logic [15:0] evt_rd_data;

  item_t sb_q[$];
  int    total;
  int    bad;
  bit    finished;

  evt_status_reg u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond_in      (cond_in),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_idx  (mode_wr_idx),
    .mode_wr_val  (mode_wr_val),
    .evt_rd_en    (evt_rd_en),
    .cond_rd_data (cond_rd_data),
    .evt_rd_data  (evt_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic drv(input logic [15:0] c, input logic rd, input logic we,
                     input logic [4:0] idx, input logic [1:0] val,
                     input logic [15:0] e_evt, input logic chk_c,
                     input logic [15:0] e_cond, input string tag);
    item_t it;
    @(negedge clk);
    cond_in     = c;
    evt_rd_en   = rd;
    mode_wr_en  = we;
    mode_wr_idx = idx;
    mode_wr_val = val;
    it.exp_evt  = e_evt;
    it.chk_cond = chk_c;
    it.exp_cond = e_cond;
    it.tag      = tag;
    sb_q.push_back(it);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: one queued item per cycle, checked after the rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        total++;
        if (evt_rd_data !== it.exp_evt ||
            (it.chk_cond && cond_rd_data !== it.exp_cond)) begin
          bad++;
          $display("FAIL %s evt=%h exp_evt=%h cond=%h exp_cond=%h",
                   it.tag, evt_rd_data, it.exp_evt, cond_rd_data, it.exp_cond);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    total = 0;
    bad = 0;
    finished = 0;
    rst_n = 1'b0;
    cond_in = '0;
    evt_rd_en = 1'b0;
    mode_wr_en = 1'b0;
    mode_wr_idx = '0;
    mode_wr_val = '0;
    repeat (3) @(negedge clk);
    // R1: the read ports are 0 while reset is held
    total++;
    if (evt_rd_data !== 16'h0 || cond_rd_data !== 16'h0) begin
      bad++;
      $display("FAIL R1 in reset evt=%h cond=%h exp=0000", evt_rd_data, cond_rd_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drv(16'h0000, 0, 0, 0,  0,     16'h0000, 1, 16'h0000, "R1");
    drv(16'hFFFF, 0, 0, 0,  0,     16'h0000, 1, 16'h5DFF, "R8/R2/R3");
    drv(16'h0000, 0, 0, 0,  0,     16'h0000, 1, 16'h0000, "R8");
    drv(16'h0000, 0, 1, 1,  2'b01, 16'h0000, 1, 16'h0000, "R4");
    drv(16'h0000, 0, 1, 2,  2'b10, 16'h0000, 1, 16'h0000, "R4");
    drv(16'h0000, 0, 1, 3,  2'b11, 16'h0000, 1, 16'h0000, "R4");
    drv(16'h0007, 0, 0, 0,  0,     16'h0005, 1, 16'h0007, "R5/R6/R7 rise");
    drv(16'h0000, 0, 0, 0,  0,     16'h0007, 1, 16'h0000, "R6/R7/R9 fall");
    drv(16'h0000, 1, 0, 0,  0,     16'h0000, 1, 16'h0000, "R10");
    drv(16'h0001, 1, 0, 0,  0,     16'h0001, 1, 16'h0001, "R11");
    drv(16'h0001, 1, 0, 0,  0,     16'h0000, 1, 16'h0001, "R10");
    drv(16'h0001, 0, 1, 17, 2'b11, 16'h0000, 1, 16'h0001, "R12");
    drv(16'h0001, 0, 1, 0,  2'b11, 16'h0000, 1, 16'h0001, "R12");
    drv(16'h0000, 0, 0, 0,  0,     16'h0000, 1, 16'h0000, "R12/R5");
    drv(16'h0004, 0, 0, 0,  0,     16'h0004, 1, 16'h0004, "R7");
    drv(16'h0004, 1, 0, 0,  0,     16'h0000, 1, 16'h0004, "R10");
    drv(16'h0004, 0, 1, 10, 2'b11, 16'h0000, 1, 16'h0004, "R4");
    drv(16'h0004, 0, 1, 16, 2'b11, 16'h0000, 1, 16'h0004, "R4");
    drv(16'h0004, 0, 1, 15, 2'b01, 16'h0000, 1, 16'h0004, "R4");
    drv(16'hC204, 0, 0, 0,  0,     16'h4000, 1, 16'h4004, "R3/R4");
    drv(16'h0004, 1, 0, 0,  0,     16'h0000, 1, 16'h0004, "R3/R5");
    drv(16'h0005, 0, 0, 0,  0,     16'h0001, 1, 16'h0005, "R5");
    drv(16'h0005, 0, 0, 0,  0,     16'h0001, 1, 16'h0005, "R9");
    drv(16'h0005, 0, 0, 0,  0,     16'h0001, 1, 16'h0005, "R9");

    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    cond_in = 16'hFFFF;
    evt_rd_en = 1'b0;
    mode_wr_en = 1'b0;
    @(negedge clk);
    // R1: the event register is cleared asynchronously
    total++;
    if (evt_rd_data !== 16'h0) begin
      bad++;
      $display("FAIL R1 async clear evt=%h exp=0000", evt_rd_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drv(16'hFFFF, 0, 0, 0, 0, 16'h0000, 0, 16'h0000, "R13");
    drv(16'hFFFF, 0, 0, 0, 0, 16'h0000, 0, 16'h0000, "R13");
    drv(16'hFFFF, 0, 0, 0, 0, 16'h0000, 1, 16'h5DFF, "R13/R2");
    drv(16'h0000, 0, 0, 0, 0, 16'h0000, 1, 16'h0000, "R1 modes NEVER");
    drv(16'h0007, 0, 0, 0, 0, 16'h0000, 1, 16'h0007, "R1 modes NEVER");

    repeat (3) @(negedge clk);
    finished = 1;
    finish_run();
  end

endmodule